// File: doc/BRIEF.md
# Transfer Byte-Count Register Set

This block holds the byte count for a bulk data transfer as three byte-wide registers that together form a 24-bit value. Host writes through a small byte register port go to a shadow copy only. A command strobe that carries the DMA flag moves the shadow into the working counter. The working counter is what the host reads back, what the data mover decrements, and what a transfer-information command turns into an effective transfer length.

The block also reports a terminal-count status bit and whether the last command selected DMA mode. Until the most significant count byte has been written after reset, reading that byte returns a fixed identification code instead of the counter. This lets software detect the block. Moving the data is done elsewhere; this block only keeps the count.

Top module: `tc_xfer_counter`

## Requirements
- R1: The working count is byte 0 (address 0) plus byte 1 (address 1) shifted left 8 plus byte 2 (address 2) shifted left 16. Each byte reads back at its own address on `reg_rdata`, combinationally, in the cycle after the write or command that set it. Address 3 reads zero.
- R2: A register write to address 0, 1 or 2 clears `tc_status` at the next edge.
- R3: A command (`cmd_valid`, any `cmd_op` other than 2'b10) with `cmd_dma`=1 copies the three shadow bytes into the working counter and sets `dma_mode`.
- R4: Register writes change only the shadow bytes and never the working count. A command with `cmd_dma`=0 leaves the working count unchanged and clears `dma_mode`.
- R5: Reading address 2 returns `CHIP_ID` (default 8'hA5) until address 2 has been written once since the last reset. After that it returns working byte 2.
- R6: A transfer-information command (`cmd_op`=2'b01) produces `xfer_len` together with a one-cycle `xfer_len_valid` pulse on the next edge. `xfer_len` is the smaller of the count and a limit. The count is taken after any load the same command does, and a count of 0 stands for 65536. The limit is `CMDBUF_LEN` (default 32) when `cmd_collect`=1 and `pending_len` otherwise.
- R7: `dec_valid` lowers the working count by 1, or by 2 when `dec_two`=1, saturating at 0. It does not change `tc_status`.
- R8: `xfer_done` clears all three working bytes and sets `tc_status`.
- R9: A software reset command (`cmd_op`=2'b10) clears the shadows, the working count, `tc_status`, `dma_mode` and the high-byte-written flag, whatever `cmd_dma` is.
- R10: After `rst_n` the count is 0, `tc_status`, `dma_mode` and `xfer_len_valid` are 0, and address 2 reads `CHIP_ID`.
- R11: For the working count, the priority is software reset, then `xfer_done`, then a DMA load, then a decrement. For `tc_status`, `xfer_done` wins over a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hard reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address, 0 low byte to 2 high byte |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| cmd_valid | input | 1 | Command strobe |
| cmd_dma | input | 1 | DMA flag of the command |
| cmd_op | input | 2 | 00 other, 01 transfer-information, 10 software reset, 11 other |
| cmd_collect | input | 1 | A command is being collected; limit is CMDBUF_LEN |
| pending_len | input | CNT_W | Pending data size in bytes |
| dec_valid | input | 1 | Decrement the working count |
| dec_two | input | 1 | Decrement step is 2 instead of 1 |
| xfer_done | input | 1 | Transfer finished |
| tc_status | output | 1 | Terminal-count status bit |
| dma_mode | output | 1 | Last command selected DMA |
| xfer_len | output | CNT_W | Effective transfer length |
| xfer_len_valid | output | 1 | One-cycle pulse when `xfer_len` is updated |

## Verification
The properties that check loads, holding, saturation and the terminal-count bit each exclude the higher-priority events in their antecedent. They therefore take for granted only that the strobes are synchronous and free of X after reset. The stimulus mostly raises one strobe per cycle, so every property is exercised on its own. The few cycles that deliberately combine a finish with a decrement, or a load with a decrement, are there to reach the priority order. The length properties assume `pending_len` is held stable across the command edge, and the bench sets it up before raising the strobe.

// File: rtl/tc_xfer_pkg.sv
package tc_xfer_pkg;
    typedef enum logic [1:0] {
        OP_OTHER = 2'b00,
        OP_XFER  = 2'b01,
        OP_SRST  = 2'b10,
        OP_SPARE = 2'b11
    } cmd_op_e;
endpackage

// File: rtl/tc_shadow_bank.sv
module tc_shadow_bank #(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [CNT_W-1:0]  shadow,
    output logic              top_written
);
    localparam int NBYTES = CNT_W / 8;

    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic             top_written;
    } bank_t;

    bank_t              st_d, st_q;
    logic [NBYTES-1:0]  byte_hit;

    for (genvar gi = 0; gi < NBYTES; gi++) begin : g_hit
        assign byte_hit[gi] = wr_en && (int'(wr_addr) == gi);
    end

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            for (int i = 0; i < NBYTES; i++) begin
                if (byte_hit[i]) st_d.shadow[i*8 +: 8] = wr_data;
            end
            if (byte_hit[NBYTES-1]) st_d.top_written = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shadow      = st_q.shadow;
    assign top_written = st_q.top_written;

    // R5: once the top byte is written, only a clear can drop the flag
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (top_written && !clear) |=> top_written);
endmodule

// File: rtl/tc_work_counter.sv
module tc_work_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             finish,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    input  logic             dec_two,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } work_t;

    work_t            st_d, st_q;
    logic [CNT_W-1:0] step;

    always_comb begin
        st_d = st_q;
        step = dec_two ? CNT_W'(2) : CNT_W'(1);
        if (clear || finish) begin
            st_d.count = '0;
        end else if (load) begin
            st_d.count = load_val;
        end else if (dec) begin
            st_d.count = (st_q.count > step) ? st_q.count - step : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;

    // R7: a lone decrement always moves down or rests at zero
    p_dec_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !clear && !finish) |=> (count < $past(count)) || (count == '0));
    // R7: never wraps upward on a decrement
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !clear && !finish) |=> count <= $past(count));
    // R8: finishing empties the counter
    p_finish_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> count == '0);
endmodule

// File: rtl/tc_len_select.sv
module tc_len_select #(
    parameter int               CNT_W      = 24,
    parameter logic [CNT_W-1:0] ZERO_LEN   = 24'h010000,
    parameter int               CMDBUF_LEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             start,
    input  logic [CNT_W-1:0] base,
    input  logic             collecting,
    input  logic [CNT_W-1:0] pending,
    output logic [CNT_W-1:0] len,
    output logic             len_valid
);
    localparam logic [CNT_W-1:0] BUF_LIM = CNT_W'(CMDBUF_LEN);

    typedef struct packed {
        logic [CNT_W-1:0] len;
        logic             valid;
    } len_t;

    len_t             st_d, st_q;
    logic [CNT_W-1:0] eff_cnt;
    logic [CNT_W-1:0] limit;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        eff_cnt    = (base == '0) ? ZERO_LEN : base;
        limit      = collecting ? BUF_LIM : pending;
        if (clear) begin
            st_d = '0;
        end else if (start) begin
            st_d.len   = (eff_cnt < limit) ? eff_cnt : limit;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign len       = st_q.len;
    assign len_valid = st_q.valid;

    // R6: never longer than the pending data
    p_len_le_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clear && !collecting) |=> len <= $past(pending));
    // R6: never longer than the command buffer while collecting
    p_len_le_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clear && collecting) |=> len <= BUF_LIM);
    // R6: a zero count never yields a zero length when data is pending
    p_len_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clear && !collecting && pending != '0) |=> len != '0);
    // R6: the valid pulse follows a start
    p_valid_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        len_valid |-> $past(start));
endmodule

// File: rtl/tc_xfer_counter.sv
module tc_xfer_counter #(
    parameter int               CNT_W      = 24,
    parameter int               ADDR_W     = 2,
    parameter logic [7:0]       CHIP_ID    = 8'hA5,
    parameter logic [CNT_W-1:0] ZERO_LEN   = 24'h010000,
    parameter int               CMDBUF_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              cmd_valid,
    input  logic              cmd_dma,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_collect,
    input  logic [CNT_W-1:0]  pending_len,
    input  logic              dec_valid,
    input  logic              dec_two,
    input  logic              xfer_done,
    output logic              tc_status,
    output logic              dma_mode,
    output logic [CNT_W-1:0]  xfer_len,
    output logic              xfer_len_valid
);
    import tc_xfer_pkg::*;

    localparam int NBYTES = CNT_W / 8;

    typedef struct packed {
        logic tc;
        logic dma;
    } stat_t;

    stat_t            st_d, st_q;
    cmd_op_e          op;
    logic             srst, load, xfer_start, cnt_wr;
    logic [CNT_W-1:0] shadow, count, len_base;
    logic             top_written;

    assign op         = cmd_op_e'(cmd_op);
    assign srst       = cmd_valid && (op == OP_SRST);
    assign load       = cmd_valid && cmd_dma && !srst;
    assign xfer_start = cmd_valid && (op == OP_XFER);
    assign cnt_wr     = reg_wr && (int'(reg_addr) < NBYTES);
    assign len_base   = load ? shadow : count;

    tc_shadow_bank #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (srst),
        .wr_en      (reg_wr),
        .wr_addr    (reg_addr),
        .wr_data    (reg_wdata),
        .shadow     (shadow),
        .top_written(top_written)
    );

    tc_work_counter #(.CNT_W(CNT_W)) u_work (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (srst),
        .finish  (xfer_done),
        .load    (load),
        .load_val(shadow),
        .dec     (dec_valid),
        .dec_two (dec_two),
        .count   (count)
    );

    tc_len_select #(.CNT_W(CNT_W), .ZERO_LEN(ZERO_LEN), .CMDBUF_LEN(CMDBUF_LEN)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (srst),
        .start     (xfer_start),
        .base      (len_base),
        .collecting(cmd_collect),
        .pending   (pending_len),
        .len       (xfer_len),
        .len_valid (xfer_len_valid)
    );

    always_comb begin
        st_d = st_q;
        if (srst) begin
            st_d = '0;
        end else begin
            if (xfer_done)   st_d.tc  = 1'b1;
            else if (cnt_wr) st_d.tc  = 1'b0;
            if (cmd_valid)   st_d.dma = cmd_dma;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (int'(reg_addr) == i) reg_rdata = count[i*8 +: 8];
        end
        if ((int'(reg_addr) == NBYTES - 1) && !top_written) reg_rdata = CHIP_ID;
    end

    assign tc_status = st_q.tc;
    assign dma_mode  = st_q.dma;

    // R3: a DMA-flagged command makes the working count equal the shadow
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !xfer_done) |=> (count == $past(shadow)) && dma_mode);
    // R4: a command without the DMA flag holds the working count
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_dma && !srst && !xfer_done && !dec_valid) |=> $stable(count) && !dma_mode);
    // R2: writing a count byte drops terminal count
    p_wr_clears_tc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !xfer_done) |=> !tc_status);
    // R8: finishing raises terminal count
    p_done_sets_tc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !srst) |=> tc_status && (count == '0));
    // R9: software reset clears status and count
    p_srst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> !tc_status && !dma_mode && (count == '0) && !top_written);
endmodule

// File: tb/tc_xfer_counter_bench.sv
module tc_xfer_counter_bench;
    localparam int         CNT_W = 24;
    localparam logic [7:0] CID   = 8'hA5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [1:0]       reg_addr = '0;
    logic [7:0]       reg_wdata = '0;
    logic [7:0]       reg_rdata;
    logic             cmd_valid = 1'b0;
    logic             cmd_dma = 1'b0;
    logic [1:0]       cmd_op = 2'b00;
    logic             cmd_collect = 1'b0;
    logic [CNT_W-1:0] pending_len = '0;
    logic             dec_valid = 1'b0;
    logic             dec_two = 1'b0;
    logic             xfer_done = 1'b0;
    logic             tc_status, dma_mode, xfer_len_valid;
    logic [CNT_W-1:0] xfer_len;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tc_xfer_counter u_tc_xfer_counter (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
        .cmd_dma(cmd_dma), .cmd_op(cmd_op), .cmd_collect(cmd_collect),
        .pending_len(pending_len), .dec_valid(dec_valid), .dec_two(dec_two),
        .xfer_done(xfer_done), .tc_status(tc_status), .dma_mode(dma_mode),
        .xfer_len(xfer_len), .xfer_len_valid(xfer_len_valid)
    );

    // {lo, mid, hi, pending, collect, expected length}
    localparam logic [72:0] VEC [8] = '{
        {8'h10, 8'h00, 8'h00, 24'h000020, 1'b0, 24'h000010},
        {8'h00, 8'h00, 8'h00, 24'h020000, 1'b0, 24'h010000},
        {8'h00, 8'h00, 8'h00, 24'h000100, 1'b0, 24'h000100},
        {8'h34, 8'h12, 8'h00, 24'h001000, 1'b0, 24'h001000},
        {8'hFF, 8'hFF, 8'hFF, 24'h00ABCD, 1'b0, 24'h00ABCD},
        {8'h05, 8'h00, 8'h00, 24'h000000, 1'b1, 24'h000005},
        {8'h00, 8'h01, 8'h00, 24'h0FFFFF, 1'b1, 24'h000020},
        {8'h00, 8'h00, 8'h01, 24'h0FFFFF, 1'b0, 24'h010000}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic cmd(input logic [1:0] op, input logic dma);
        cmd_valid = 1'b1; cmd_op = op; cmd_dma = dma;
        tick();
        cmd_valid = 1'b0; cmd_dma = 1'b0; cmd_op = 2'b00;
    endtask

    task automatic count_is(string req, logic [23:0] exp);
        logic [7:0] b0, b1, b2;
        rd(2'd0, b0); rd(2'd1, b1); rd(2'd2, b2);
        check(req, {8'h00, b2, b1, b0}, {8'h00, exp});
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R10: reset state
        rd(2'd0, b); check("R10 low byte", b, 8'h00);
        rd(2'd1, b); check("R10 mid byte", b, 8'h00);
        rd(2'd2, b); check("R10 id byte", b, CID);
        check("R10 tc", tc_status, 1'b0);
        check("R10 dma", dma_mode, 1'b0);
        check("R10 len valid", xfer_len_valid, 1'b0);
        rd(2'd3, b); check("R1 unused address", b, 8'h00);

        // R1 R3 R6: vector walk
        foreach (VEC[i]) begin
            wr(2'd0, VEC[i][72:65]);
            wr(2'd1, VEC[i][64:57]);
            wr(2'd2, VEC[i][56:49]);
            pending_len = VEC[i][48:25];
            cmd_collect = VEC[i][24];
            cmd(2'b01, 1'b1);
            check("R6 valid pulse", xfer_len_valid, 1'b1);
            check("R6 length", xfer_len, VEC[i][23:0]);
            check("R3 dma mode", dma_mode, 1'b1);
            count_is("R1 R3 readback", {VEC[i][56:49], VEC[i][64:57], VEC[i][72:65]});
            tick();
            check("R6 pulse ends", xfer_len_valid, 1'b0);
        end
        cmd_collect = 1'b0;

        // R8: finish
        xfer_done = 1'b1; tick(); xfer_done = 1'b0;
        check("R8 tc set", tc_status, 1'b1);
        count_is("R8 count cleared", 24'h0);

        // R2 R4: write clears tc, not working count
        wr(2'd1, 8'h44);
        check("R2 tc cleared", tc_status, 1'b0);
        count_is("R4 write leaves working", 24'h0);
        cmd(2'b00, 1'b0);
        check("R4 non-dma mode", dma_mode, 1'b0);
        count_is("R4 non-dma hold", 24'h0);
        cmd(2'b00, 1'b1);
        count_is("R3 load from shadow", 24'h014400);

        // R7: decrement and saturation
        wr(2'd0, 8'h03); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        cmd(2'b00, 1'b1);
        dec_valid = 1'b1; dec_two = 1'b1; tick();
        count_is("R7 step two", 24'h000001);
        tick();
        count_is("R7 saturate step two", 24'h000000);
        dec_two = 1'b0; tick(); dec_valid = 1'b0;
        count_is("R7 saturate step one", 24'h000000);
        check("R7 tc unaffected", tc_status, 1'b0);

        // R11: priorities
        wr(2'd0, 8'h05);
        cmd(2'b00, 1'b1);
        xfer_done = 1'b1; dec_valid = 1'b1; tick(); xfer_done = 1'b0; dec_valid = 1'b0;
        count_is("R11 done over dec", 24'h0);
        check("R11 tc after done", tc_status, 1'b1);
        cmd_valid = 1'b1; cmd_dma = 1'b1; dec_valid = 1'b1; tick();
        cmd_valid = 1'b0; cmd_dma = 1'b0; dec_valid = 1'b0;
        count_is("R11 load over dec", 24'h000005);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h05; xfer_done = 1'b1; tick();
        reg_wr = 1'b0; xfer_done = 1'b0;
        check("R11 done over write for tc", tc_status, 1'b1);

        // R9 R5: software reset
        wr(2'd2, 8'h07);
        cmd(2'b10, 1'b1);
        count_is("R9 count cleared", {CID, 16'h0000});
        check("R9 tc", tc_status, 1'b0);
        check("R9 dma", dma_mode, 1'b0);
        cmd(2'b00, 1'b1);
        rd(2'd0, b); check("R9 shadow cleared", b, 8'h00);
        rd(2'd2, b); check("R5 id until written", b, CID);
        wr(2'd2, 8'h00);
        rd(2'd2, b); check("R5 counter byte after write", b, 8'h00);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule